// File: doc/BRIEF.md
# Multi-Step Trigger Sequencer

This block is a trigger engine of the kind found in a logic analyzer. Every clock cycle it compares a 32-bit bus of sense signals against the match slots of its current step. A match can move it to another step, bump a per-step event counter, or fire the trigger. Because the step index persists from one cycle to the next, the engine recognises orderings of events spread over time, not only a single-cycle pattern. Firing produces a one-cycle trigger pulse and sets a sticky interrupt.

Software sets the engine up through a simple write port and a combinational read port. There is one control word (enable, re-arm), one status word, and per-step configuration words for up to eight steps. Step configuration can only be changed while the engine is disabled. Raising the enable bit starts observation at step 0.

Addresses are 8 bits wide. Address 0x00 is the control word and 0x01 is the status word. A step word lives at 0x80 + 16*step + field, where field is one of:
- 0..3: slot mask
- 4..7: slot value
- 8..11: slot action
- 12: step condition
- 13: step timer

Top module: `trig_seq`

## Requirements
- R1: After reset the status word reads 0, the control word reads 0, and `trig` and `irq` are 0.
- R2: A slot matches when `(sense & mask) == (value & mask)`. A slot whose mask is all zero never matches.
- R3: When several slots match in one cycle, the lowest-numbered slot alone decides the action.
- R4: On the first clock edge after the enable bit (control bit 0) becomes 1, the engine goes to step 0 with counter and timer cleared, and it evaluates nothing. From the next edge on it evaluates the current step. An advance action (slot action bits [1:0] = 0, target in bits [6:4]) puts the target step in the status step field after that edge. While the engine is disabled, its state holds.
- R5: A count action (action code 1) adds one to the step counter. When the new count reaches the step's terminal count (condition bits [15:0]), the condition action is taken. That action fires if condition bit 31 is 1; otherwise the engine goes to the step in condition bits [26:24]. Every step entry clears the counter.
- R6: Timer bits [15:0] give a limit (0 turns the timer off). After that many consecutive evaluated cycles with no slot match in the current step, the engine enters the timeout step in timer bits [26:24]. Any count match restarts the timer.
- R7: A fire (action code 2 or 3, or a firing condition) drives `trig` high for exactly the one cycle after the deciding edge. It also sets `irq` and the status triggered flag. `irq` stays set until a status write with bit 6 = 1, and a status write with bit 6 = 0 leaves it set.
- R8: After a fire, if the re-arm bit (control bit 1) is 1 the engine returns to step 0 and keeps running. Otherwise it halts: status halted = 1, running = 0, the step holds, and no further trigger occurs until enable is taken low and then high again, which clears the triggered and halted flags.
- R9: Step-word writes are ignored while enable is 1 and are stored while it is 0. Every stored step word reads back as written. The control word is writable at all times.
- R10: The status word reads at any time as: step index in bits [2:0], triggered in bit 4, halted in bit 5, irq in bit 6, running in bit 7, and counter in bits [31:16].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sense | input | 32 | Observed signals |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 32 | Combinational read data |
| trig | output | 1 | One-cycle trigger pulse |
| irq | output | 1 | Sticky interrupt |

## Verification
Sense patterns are applied in the right order and in the wrong order. This shows that detection depends on the sequence across cycles and not on any single pattern. One value matches a broad-mask slot but not a narrow one, and a second value matches both. Together with a zero-mask slot that would otherwise fire, these show the masking rule apart from the slot priority. Repeated single-bit pulses toward a terminal count, idle sense toward a timer limit, and firing with and without re-arm separate the counting, timeout and halt paths.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
    localparam int SENSE_W    = 32;
    localparam int DATA_W     = 32;
    localparam int NUM_STEPS  = 8;
    localparam int NUM_SLOTS  = 4;
    localparam int CNT_W      = 16;
    localparam int STEP_W     = $clog2(NUM_STEPS);
    localparam int FIELD_W    = 4;
    localparam int NUM_FIELDS = 3 * NUM_SLOTS + 2;
    localparam int ADDR_W     = 1 + STEP_W + FIELD_W;

    localparam int F_MASK0 = 0;
    localparam int F_VAL0  = NUM_SLOTS;
    localparam int F_ACT0  = 2 * NUM_SLOTS;
    localparam int F_COND  = 3 * NUM_SLOTS;
    localparam int F_TIMER = 3 * NUM_SLOTS + 1;

    localparam logic [ADDR_W-1:0] CTRL_ADDR   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(1);

    localparam int ACT_TGT_LSB  = 4;
    localparam int COND_TGT_LSB = 24;
    localparam int COND_FIRE_B  = 31;
    localparam int TMR_TGT_LSB  = 24;
    localparam int IRQ_CLR_B    = 6;

    typedef enum logic [1:0] {
        ACT_ADVANCE = 2'd0,
        ACT_COUNT   = 2'd1,
        ACT_FIRE    = 2'd2,
        ACT_FIRE2   = 2'd3
    } act_e;

    typedef struct packed {
        logic [SENSE_W-1:0] mask;
        logic [SENSE_W-1:0] value;
        act_e               act;
        logic [STEP_W-1:0]  target;
    } slot_cfg_t;

    typedef struct packed {
        slot_cfg_t [NUM_SLOTS-1:0] slots;
        logic [CNT_W-1:0]          term;
        logic                      cond_fire;
        logic [STEP_W-1:0]         cond_target;
        logic [CNT_W-1:0]          tlimit;
        logic [STEP_W-1:0]         tstep;
    } step_cfg_t;

    typedef struct packed {
        logic enable;
        logic rearm;
    } ctrl_t;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  tmr;
        logic              en_prev;
        logic              halted;
        logic              triggered;
        logic              trig;
        logic              irq;
    } eng_state_t;
endpackage

// File: rtl/trig_seq_cfg.sv
module trig_seq_cfg
    import trig_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] status_i,
    input  logic [STEP_W-1:0] cur_step_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              enable_o,
    output logic              rearm_o,
    output logic              irq_clr_o,
    output step_cfg_t         cfg_o
);
    ctrl_t             ctrl_d, ctrl_q;
    logic [DATA_W-1:0] word_d [NUM_STEPS][NUM_FIELDS];
    logic [DATA_W-1:0] word_q [NUM_STEPS][NUM_FIELDS];

    logic              wr_is_step, wr_fld_ok;
    logic [STEP_W-1:0] wr_s;
    logic [FIELD_W-1:0] wr_f;
    logic              rd_is_step, rd_fld_ok;
    logic [STEP_W-1:0] rd_s;
    logic [FIELD_W-1:0] rd_f;

    assign wr_is_step = wr_addr[ADDR_W-1];
    assign wr_s       = wr_addr[FIELD_W +: STEP_W];
    assign wr_f       = wr_addr[FIELD_W-1:0];
    assign wr_fld_ok  = wr_f < FIELD_W'(NUM_FIELDS);
    assign rd_is_step = rd_addr[ADDR_W-1];
    assign rd_s       = rd_addr[FIELD_W +: STEP_W];
    assign rd_f       = rd_addr[FIELD_W-1:0];
    assign rd_fld_ok  = rd_f < FIELD_W'(NUM_FIELDS);

    always_comb begin
        ctrl_d = ctrl_q;
        word_d = word_q;
        if (wr_en && wr_addr == CTRL_ADDR) begin
            ctrl_d.enable = wr_data[0];
            ctrl_d.rearm  = wr_data[1];
        end
        if (wr_en && wr_is_step && wr_fld_ok && !ctrl_q.enable) begin
            word_d[wr_s][wr_f] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            for (int s = 0; s < NUM_STEPS; s++) begin
                for (int f = 0; f < NUM_FIELDS; f++) begin
                    word_q[s][f] <= '0;
                end
            end
        end else begin
            ctrl_q <= ctrl_d;
            word_q <= word_d;
        end
    end

    assign enable_o  = ctrl_q.enable;
    assign rearm_o   = ctrl_q.rearm;
    assign irq_clr_o = wr_en && (wr_addr == STATUS_ADDR) && wr_data[IRQ_CLR_B];

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_ADDR) begin
            rd_data[0] = ctrl_q.enable;
            rd_data[1] = ctrl_q.rearm;
        end else if (rd_addr == STATUS_ADDR) begin
            rd_data = status_i;
        end else if (rd_is_step && rd_fld_ok) begin
            rd_data = word_q[rd_s][rd_f];
        end
    end

    generate
        for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot_dec
            assign cfg_o.slots[k].mask   = word_q[cur_step_i][F_MASK0 + k];
            assign cfg_o.slots[k].value  = word_q[cur_step_i][F_VAL0 + k];
            assign cfg_o.slots[k].act    = act_e'(word_q[cur_step_i][F_ACT0 + k][1:0]);
            assign cfg_o.slots[k].target = word_q[cur_step_i][F_ACT0 + k][ACT_TGT_LSB +: STEP_W];
        end
    endgenerate

    assign cfg_o.term        = word_q[cur_step_i][F_COND][CNT_W-1:0];
    assign cfg_o.cond_fire   = word_q[cur_step_i][F_COND][COND_FIRE_B];
    assign cfg_o.cond_target = word_q[cur_step_i][F_COND][COND_TGT_LSB +: STEP_W];
    assign cfg_o.tlimit      = word_q[cur_step_i][F_TIMER][CNT_W-1:0];
    assign cfg_o.tstep       = word_q[cur_step_i][F_TIMER][TMR_TGT_LSB +: STEP_W];

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CTRL_ADDR) |=> (enable_o == $past(wr_data[0]))); // R9
endmodule

// File: rtl/trig_seq_match.sv
module trig_seq_match
    import trig_seq_pkg::*;
(
    input  logic [SENSE_W-1:0]       sense_i,
    input  slot_cfg_t [NUM_SLOTS-1:0] slots_i,
    output logic                      hit_o,
    output act_e                      act_o,
    output logic [STEP_W-1:0]         target_o
);
    logic [NUM_SLOTS-1:0] raw;
    logic [NUM_SLOTS-1:0] grant;

    generate
        for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cmp
            assign raw[k] = (|slots_i[k].mask) &&
                ((sense_i & slots_i[k].mask) == (slots_i[k].value & slots_i[k].mask));
        end
    endgenerate

    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (raw[k] && !found) begin
                grant[k] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        act_o    = ACT_ADVANCE;
        target_o = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (grant[k]) begin
                act_o    = slots_i[k].act;
                target_o = slots_i[k].target;
            end
        end
    end

    assign hit_o = |raw;
endmodule

// File: rtl/trig_seq_engine.sv
module trig_seq_engine
    import trig_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              rearm_i,
    input  logic              irq_clr_i,
    input  step_cfg_t         cfg_i,
    input  logic              hit_i,
    input  act_e              act_i,
    input  logic [STEP_W-1:0] target_i,
    output logic [STEP_W-1:0] step_o,
    output logic [DATA_W-1:0] status_o,
    output logic              trig_o,
    output logic              irq_o
);
    eng_state_t s_d, s_q;

    always_comb begin
        logic              fire;
        logic              go;
        logic [STEP_W-1:0] go_step;
        logic [CNT_W:0]    cnt_n;
        logic [CNT_W:0]    tmr_n;

        s_d     = s_q;
        s_d.trig    = 1'b0;
        s_d.en_prev = enable_i;
        fire    = 1'b0;
        go      = 1'b0;
        go_step = '0;
        cnt_n   = {1'b0, s_q.cnt} + 1'b1;
        tmr_n   = {1'b0, s_q.tmr} + 1'b1;

        if (irq_clr_i) s_d.irq = 1'b0;

        if (enable_i && !s_q.en_prev) begin
            s_d.step      = '0;
            s_d.cnt       = '0;
            s_d.tmr       = '0;
            s_d.halted    = 1'b0;
            s_d.triggered = 1'b0;
        end else if (enable_i && !s_q.halted) begin
            if (hit_i) begin
                unique case (act_i)
                    ACT_ADVANCE: begin
                        go      = 1'b1;
                        go_step = target_i;
                    end
                    ACT_COUNT: begin
                        s_d.tmr = '0;
                        if (cnt_n >= {1'b0, cfg_i.term}) begin
                            if (cfg_i.cond_fire) begin
                                fire = 1'b1;
                            end else begin
                                go      = 1'b1;
                                go_step = cfg_i.cond_target;
                            end
                        end else begin
                            s_d.cnt = cnt_n[CNT_W-1:0];
                        end
                    end
                    default: fire = 1'b1;
                endcase
            end else if (cfg_i.tlimit != '0 && tmr_n >= {1'b0, cfg_i.tlimit}) begin
                go      = 1'b1;
                go_step = cfg_i.tstep;
            end else begin
                s_d.tmr = tmr_n[CNT_W-1:0];
            end

            if (fire) begin
                s_d.trig      = 1'b1;
                s_d.irq       = 1'b1;
                s_d.triggered = 1'b1;
                s_d.cnt       = '0;
                s_d.tmr       = '0;
                if (rearm_i) begin
                    go      = 1'b1;
                    go_step = '0;
                end else begin
                    s_d.halted = 1'b1;
                end
            end

            if (go) begin
                s_d.step = go_step;
                s_d.cnt  = '0;
                s_d.tmr  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        status_o = '0;
        status_o[STEP_W-1:0]  = s_q.step;
        status_o[4]           = s_q.triggered;
        status_o[5]           = s_q.halted;
        status_o[6]           = s_q.irq;
        status_o[7]           = enable_i && !s_q.halted;
        status_o[16 +: CNT_W] = s_q.cnt;
    end

    assign step_o = s_q.step;
    assign trig_o = s_q.trig;
    assign irq_o  = s_q.irq;

    AST_TRIG_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> irq_o); // R7
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.halted |=> !trig_o); // R8
    AST_ENTRY_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.step != $past(s_q.step)) |-> (s_q.cnt == '0)); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> $stable(s_q.step)); // R4
endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trig_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SENSE_W-1:0] sense,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              trig,
    output logic              irq
);
    logic              enable, rearm, irq_clr, hit;
    logic [STEP_W-1:0] cur_step, target;
    logic [DATA_W-1:0] status;
    step_cfg_t         cfg;
    act_e              act;

    trig_seq_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .status_i   (status),
        .cur_step_i (cur_step),
        .rd_data    (rd_data),
        .enable_o   (enable),
        .rearm_o    (rearm),
        .irq_clr_o  (irq_clr),
        .cfg_o      (cfg)
    );

    trig_seq_match u_match (
        .sense_i  (sense),
        .slots_i  (cfg.slots),
        .hit_o    (hit),
        .act_o    (act),
        .target_o (target)
    );

    trig_seq_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (enable),
        .rearm_i   (rearm),
        .irq_clr_i (irq_clr),
        .cfg_i     (cfg),
        .hit_i     (hit),
        .act_i     (act),
        .target_i  (target),
        .step_o    (cur_step),
        .status_o  (status),
        .trig_o    (trig),
        .irq_o     (irq)
    );
endmodule

// File: tb/trig_seq_bench.sv
`timescale 1ns/1ps
module trig_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] sense = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        trig, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    trig_seq u_trig_seq (
        .clk(clk), .rst_n(rst_n), .sense(sense), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .trig(trig), .irq(irq)
    );

    function automatic logic [7:0] sa(input int s, input int f);
        return 8'h80 | 8'(s << 4) | 8'(f);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic start(input bit rearm);
        wr(8'h00, {30'b0, rearm, 1'b1});
        @(negedge clk);
    endtask

    task automatic apply(input logic [31:0] v);
        sense = v;
        @(negedge clk);
    endtask

    task automatic wipe();
        wr(8'h00, 32'h0);
        sense = '0;
        for (int s = 0; s < 8; s++)
            for (int f = 0; f < 14; f++)
                wr(sa(s, f), 32'h0);
        wr(8'h01, 32'h40);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h01, d); chk("R1", "status", d, 32'h0);
        rd(8'h00, d); chk("R1", "ctrl", d, 32'h0);
        chk("R1", "trig", {31'b0, trig}, 32'h0);
        chk("R1", "irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_sequence_halt();
        logic [31:0] d;
        wipe();
        wr(sa(0, 0), 32'h0000_00FF); wr(sa(0, 4), 32'h0000_00A5); wr(sa(0, 8), 32'h10);
        wr(sa(1, 0), 32'h0000_FF00); wr(sa(1, 4), 32'h0000_3C00); wr(sa(1, 8), 32'h2);
        start(1'b0);
        rd(8'h01, d); chk("R4", "start step0 running", d, 32'h80);
        apply(32'h3C00);
        rd(8'h01, d); chk("R4", "wrong order stays step0", d[2:0], 3'd0);
        chk("R7", "no trig out of order", {31'b0, trig}, 0);
        apply(32'h00A5);
        rd(8'h01, d); chk("R4", "advance to step1", d[2:0], 3'd1);
        apply(32'h3C00);
        chk("R7", "trig pulse", {31'b0, trig}, 1);
        chk("R7", "irq set", {31'b0, irq}, 1);
        rd(8'h01, d); chk("R10", "status after fire", d, 32'h71);
        apply(32'h3C00);
        chk("R7", "trig one cycle", {31'b0, trig}, 0);
        apply(32'h3C00);
        chk("R8", "halted no retrigger", {31'b0, trig}, 0);
        rd(8'h01, d); chk("R8", "halted holds step1", d, 32'h71);
        wr(8'h01, 32'h0);
        chk("R7", "irq kept on bit6=0", {31'b0, irq}, 1);
        wr(8'h01, 32'h40);
        chk("R7", "irq cleared on bit6=1", {31'b0, irq}, 0);
        sense = '0;
        wr(8'h00, 32'h0);
        start(1'b0);
        rd(8'h01, d); chk("R8", "re-enable restarts", d, 32'h80);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        wipe();
        wr(sa(0, 0), 32'h0); wr(sa(0, 4), 32'h0); wr(sa(0, 8), 32'h2);
        wr(sa(0, 1), 32'hF); wr(sa(0, 5), 32'h1); wr(sa(0, 9), 32'h20);
        wr(sa(0, 2), 32'h1); wr(sa(0, 6), 32'h1); wr(sa(0, 10), 32'h30);
        start(1'b0);
        apply(32'h3);
        rd(8'h01, d); chk("R2", "mask selects slot2", d[2:0], 3'd3);
        chk("R2", "zero mask slot silent", {31'b0, trig}, 0);
        sense = '0;
        wr(8'h00, 32'h0);
        start(1'b0);
        apply(32'h1);
        rd(8'h01, d); chk("R3", "slot1 beats slot2", d[2:0], 3'd2);
        chk("R3", "no trig", {31'b0, trig}, 0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        wipe();
        wr(sa(0, 0), 32'h1); wr(sa(0, 4), 32'h1); wr(sa(0, 8), 32'h1);
        wr(sa(0, 12), 32'h0500_0003);
        start(1'b0);
        apply(32'h1); apply(32'h0);
        rd(8'h01, d); chk("R5", "count 1", d, 32'h0001_0080);
        apply(32'h1); apply(32'h0);
        rd(8'h01, d); chk("R5", "count 2", d, 32'h0002_0080);
        apply(32'h1);
        rd(8'h01, d); chk("R5", "terminal goes step5 cnt0", d, 32'h0000_0085);
    endtask

    task automatic t_timer();
        logic [31:0] d;
        wipe();
        wr(sa(0, 13), 32'h0600_0004);
        start(1'b0);
        apply(32'h0); apply(32'h0); apply(32'h0);
        rd(8'h01, d); chk("R6", "before limit", d[2:0], 3'd0);
        apply(32'h0);
        rd(8'h01, d); chk("R6", "timeout step6", d[2:0], 3'd6);
    endtask

    task automatic t_rearm();
        logic [31:0] d;
        wipe();
        wr(sa(0, 0), 32'hFF); wr(sa(0, 4), 32'hA5); wr(sa(0, 8), 32'h10);
        wr(sa(1, 0), 32'hFF00); wr(sa(1, 4), 32'h3C00); wr(sa(1, 8), 32'h3);
        start(1'b1);
        apply(32'hA5); apply(32'h3C00);
        chk("R8", "rearm first trig", {31'b0, trig}, 1);
        rd(8'h01, d); chk("R8", "rearm back to step0 running", d, 32'hD0);
        apply(32'hA5); apply(32'h3C00);
        chk("R8", "rearm second trig", {31'b0, trig}, 1);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        wipe();
        wr(sa(2, 3), 32'h1234_5678);
        rd(sa(2, 3), d); chk("R9", "write while disabled", d, 32'h1234_5678);
        wr(sa(7, 13), 32'hCAFE_0001);
        rd(sa(7, 13), d); chk("R9", "timer word readback", d, 32'hCAFE_0001);
        start(1'b0);
        wr(sa(2, 3), 32'hDEAD_BEEF);
        rd(sa(2, 3), d); chk("R9", "write ignored while enabled", d, 32'h1234_5678);
        wr(8'h00, 32'h3);
        rd(8'h00, d); chk("R9", "ctrl writable while enabled", d, 32'h3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sequence_halt();
        t_priority();
        t_count();
        t_timer();
        t_rearm();
        t_lock();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule